// File: doc/BRIEF.md
# Victim-Aggressor Crosstalk Pattern Line Generator

This engine fills consecutive lines of a test-pattern buffer with victim/aggressor crosstalk stimulus. It is given a victim lane mask, an aggressor lane mask, a line count and a first line number. Each lane receives an 8-beat burst that depends on whether the lane is a victim and whether it is an aggressor. Each generated line is sent out as eight chunk-write transactions. Each transaction carries the line number, the chunk index and 64 bits of data.

After a line is finished, both masks rotate left by one lane, so the stressed lanes move along the bus from one line to the next. A typical fill runs in two stages. The first stage uses victim mask 0x01010101 with no aggressors for 8 lines from line 0. The second stage uses victim mask 0x41041041 with nine aggressor masks, 6 lines each, starting at line 8 + 6*a. Together these cover 62 lines.

Software or a training sequencer pulses `start` while the engine is idle. It then consumes writes through a valid/ready pair and waits for the single-cycle `done` pulse.

Top module: `va_line_gen`

## Requirements
- R1: After reset, `busy`, `done` and `wr_valid` are low.
- R2: Each lane b has a 2-bit class code. Bit 1 is the inverse of victim bit b and bit 0 is aggressor bit b. Code 0 selects burst byte 0xAA, code 1 selects 0xC0, code 2 selects 0xCC and code 3 selects 0xF0.
- R3: In chunk c (0..7) of a line, bit b of the 32-bit chunk word equals bit c of lane b's burst byte.
- R4: `wr_data[63:32]` and `wr_data[31:0]` both carry the same 32-bit chunk word.
- R5: Line v of a job, for v from 0 to count-1, is written to `wr_line` = first line + v, taken modulo 2^LINE_W.
- R6: Line v uses both masks rotated left by v lanes, with bit 31 wrapping into bit 0 after each line.
- R7: Within a line, chunks go out in order 0 to 7, one per cycle in which `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, line, chunk and data hold steady.
- R8: A start with a line count of zero produces `done` in the next cycle with no write and without raising `busy`.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the running job.
- R10: `done` is a one-cycle pulse in the cycle after the last chunk of the last line is accepted. `busy` and `wr_valid` are low in that same cycle.
- R11: `wr_valid` is high in every busy cycle, starting in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (ignored while busy) |
| agg_mask | input | LANES (32) | Aggressor lane mask for line 0 |
| vic_mask | input | LANES (32) | Victim lane mask for line 0 |
| line_count | input | ROT_W (8) | Number of lines (rotations) to produce |
| first_line | input | LINE_W (12) | Buffer line that receives line 0 |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Chunk write is offered |
| wr_ready | input | 1 | Sink accepts the offered chunk |
| wr_line | output | LINE_W (12) | Destination buffer line |
| wr_chunk | output | 3 | Chunk index within the line |
| wr_data | output | 2*LANES (64) | Chunk data, word duplicated in both halves |

## Verification
The bench uses the default build: 32 lanes, a 12-bit line number and an 8-bit line count. With these widths a job starting at line 4090 wraps the line number. Jobs of 40 and 70 lines rotate the masks through more than one full turn, so the wrap of bit 31 into bit 0 is exercised again and again. Random ready throttling, down to 30 percent, produces long stalls in the middle of a line. The full 62-line fill is replayed against a burst model written with its own decode.

// File: rtl/va_pkg.sv
package va_pkg;
  localparam int CHUNKS  = 8;
  localparam int CHUNK_W = $clog2(CHUNKS);

  typedef enum logic [1:0] {
    CLS_VIC_QUIET = 2'd0,
    CLS_VIC_AGG   = 2'd1,
    CLS_QUIET     = 2'd2,
    CLS_AGG       = 2'd3
  } lane_class_e;

  function automatic lane_class_e lane_class(input logic vic, input logic agg);
    return lane_class_e'({~vic, agg});
  endfunction

  function automatic logic [CHUNKS-1:0] class_burst(input lane_class_e cls);
    logic [CHUNKS-1:0] b;
    unique case (cls)
      CLS_VIC_QUIET: b = 8'hAA;
      CLS_VIC_AGG:   b = 8'hC0;
      CLS_QUIET:     b = 8'hCC;
      default:       b = 8'hF0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/va_mask_reg.sv
module va_mask_reg #(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LANES-1:0] agg_in,
  input  logic [LANES-1:0] vic_in,
  output logic [LANES-1:0] agg_q,
  output logic [LANES-1:0] vic_q
);
  logic [LANES-1:0] agg_rot, vic_rot;
  assign agg_rot = {agg_q[LANES-2:0], agg_q[LANES-1]};
  assign vic_rot = {vic_q[LANES-2:0], vic_q[LANES-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      agg_q <= '0;
      vic_q <= '0;
    end else if (load) begin
      agg_q <= agg_in;
      vic_q <= vic_in;
    end else if (step) begin
      agg_q <= agg_rot;
      vic_q <= vic_rot;
    end
  end

  // R6: a finished line leaves both masks rotated by exactly one lane
  a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> (vic_q == $past(vic_rot)) && (agg_q == $past(agg_rot))
      && ($countones(vic_q) == $past($countones(vic_q))));
endmodule

// File: rtl/va_chunk_builder.sv
module va_chunk_builder
  import va_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0]   agg,
  input  logic [LANES-1:0]   vic,
  input  logic [CHUNK_W-1:0] chunk,
  output logic [2*LANES-1:0] data
);
  logic [LANES-1:0] word;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [CHUNKS-1:0] burst;
    assign burst   = class_burst(lane_class(vic[b], agg[b]));
    assign word[b] = burst[chunk];
  end

  assign data = {word, word};
endmodule

// File: rtl/va_seq.sv
module va_seq
  import va_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int ROT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROT_W-1:0]   line_count,
  input  logic [LINE_W-1:0]  first_line,
  input  logic               wr_ready,
  output logic               load,
  output logic               line_step,
  output logic               busy,
  output logic               done,
  output logic [CHUNK_W-1:0] chunk,
  output logic [LINE_W-1:0]  line
);
  logic             busy_q, done_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic [LINE_W-1:0]  line_q;
  logic [ROT_W-1:0]   left_q;
  logic accept, last_chunk, last_line;

  assign load       = start && !busy_q;
  assign accept     = busy_q && wr_ready;
  assign last_chunk = (chunk_q == CHUNK_W'(CHUNKS - 1));
  assign last_line  = (left_q == ROT_W'(1));
  assign line_step  = accept && last_chunk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      chunk_q <= '0;
      line_q  <= '0;
      left_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        if (line_count == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          chunk_q <= '0;
          line_q  <= first_line;
          left_q  <= line_count;
        end
      end else if (accept) begin
        if (last_chunk) begin
          chunk_q <= '0;
          if (last_line) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            line_q <= line_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
        end else begin
          chunk_q <= chunk_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign chunk = chunk_q;
  assign line  = line_q;

  // R7: an accepted non-final chunk is followed by the next chunk index
  a_r7_chunk_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_chunk |=> busy_q && (chunk_q == $past(chunk_q) + 1'b1));
  // R5: a completed non-final line moves to the next buffer line, chunk 0
  a_r5_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    line_step && !last_line |=> busy_q && (line_q == $past(line_q) + 1'b1) && (chunk_q == '0));
  // R8: zero-length job completes at once without going busy
  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    load && (line_count == '0) |=> done_q && !busy_q);
endmodule

// File: rtl/va_line_gen.sv
module va_line_gen
  import va_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int LINE_W = 12,
  parameter int ROT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LANES-1:0]   agg_mask,
  input  logic [LANES-1:0]   vic_mask,
  input  logic [ROT_W-1:0]   line_count,
  input  logic [LINE_W-1:0]  first_line,
  output logic               busy,
  output logic               done,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [LINE_W-1:0]  wr_line,
  output logic [CHUNK_W-1:0] wr_chunk,
  output logic [2*LANES-1:0] wr_data
);
  logic load, line_step;
  logic [LANES-1:0] agg_cur, vic_cur;

  va_seq #(.LINE_W(LINE_W), .ROT_W(ROT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .line_count(line_count),
    .first_line(first_line), .wr_ready(wr_ready), .load(load),
    .line_step(line_step), .busy(busy), .done(done), .chunk(wr_chunk),
    .line(wr_line)
  );

  va_mask_reg #(.LANES(LANES)) u_masks (
    .clk(clk), .rst_n(rst_n), .load(load), .step(line_step),
    .agg_in(agg_mask), .vic_in(vic_mask), .agg_q(agg_cur), .vic_q(vic_cur)
  );

  va_chunk_builder #(.LANES(LANES)) u_build (
    .agg(agg_cur), .vic(vic_cur), .chunk(wr_chunk), .data(wr_data)
  );

  assign wr_valid = busy;

  // R7: a stalled offer holds line, chunk and data
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_line) && $stable(wr_chunk));
  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: completion never coincides with an offered write
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_valid);
  // R9: start during a job does not restart it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(wr_ready && wr_chunk == CHUNK_W'(CHUNKS - 1))
      |=> busy && $stable(wr_line));
endmodule

// File: tb/sim_va_line_gen.sv
module sim_va_line_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] agg_mask = '0, vic_mask = '0;
  logic [7:0]  line_count = '0;
  logic [11:0] first_line = '0;
  logic busy, done, wr_valid;
  logic wr_ready = 1'b0;
  logic [11:0] wr_line;
  logic [2:0]  wr_chunk;
  logic [63:0] wr_data;

  int total = 0, bad = 0;
  int cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  va_line_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .agg_mask(agg_mask),
    .vic_mask(vic_mask), .line_count(line_count), .first_line(first_line),
    .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_line(wr_line), .wr_chunk(wr_chunk), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rot_by(input logic [31:0] m, input int v);
    int s = v % 32;
    if (s == 0) return m;
    return (m << s) | (m >> (32 - s));
  endfunction

  // burst bit for chunk c of a lane, decoded from victim/aggressor directly (R2, R3)
  function automatic logic burst_bit(input logic vb, input logic ab, input int c);
    logic [7:0] aa = 8'hAA, c0 = 8'hC0, cc = 8'hCC, f0 = 8'hF0;
    if (vb) return ab ? c0[c] : aa[c];
    return ab ? f0[c] : cc[c];
  endfunction

  function automatic logic [63:0] exp_data(input logic [31:0] ag, input logic [31:0] vi, input int v, input int c);
    logic [31:0] ra = rot_by(ag, v), rv = rot_by(vi, v), w;
    for (int b = 0; b < 32; b++) w[b] = burst_bit(rv[b], ra[b], c);
    return {w, w}; // R4
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_job(input logic [31:0] ag, input logic [31:0] vi, input logic [7:0] cnt,
                         input logic [11:0] base, input int rdy_pct, input bit poke);
    int v = 0, c = 0;
    bit rdy;
    logic [63:0] ed;
    logic [11:0] el;
    @(negedge clk);
    agg_mask = ag; vic_mask = vi; line_count = cnt; first_line = base; start = 1'b1;
    wr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    agg_mask = $urandom; vic_mask = $urandom;
    if (cnt == 0) begin
      check(done && !busy && !wr_valid, "R8 zero count done", {61'd0, done, busy, wr_valid}, 64'h4);
      @(negedge clk);
      check(!done && !wr_valid, "R8 no writes after", {62'd0, done, wr_valid}, 64'h0);
      return;
    end
    check(busy && wr_valid, "R11 valid with busy", {62'd0, busy, wr_valid}, 64'h3);
    while (v < cnt) begin
      ed = exp_data(ag, vi, v, c);
      el = base + 12'(v);
      check(wr_valid && busy, "R11 valid during job", {62'd0, wr_valid, busy}, 64'h3);
      check(wr_line == el, "R5 line", 64'(wr_line), 64'(el));
      check(wr_chunk == 3'(c), "R7 chunk order", 64'(wr_chunk), 64'(c));
      check(wr_data == ed, "R2 R3 R4 R6 data", wr_data, ed);
      rdy = (($urandom % 100) < rdy_pct);
      wr_ready = rdy;
      if (poke && v == 0 && c == 2) begin
        start = 1'b1; line_count = 8'd0; first_line = 12'hABC; // R9
      end
      @(negedge clk);
      start = 1'b0;
      if (rdy) begin
        c++;
        if (c == 8) begin c = 0; v++; end
      end
    end
    wr_ready = 1'b0;
    check(done && !busy && !wr_valid, "R10 done after last", {61'd0, done, busy, wr_valid}, 64'h4);
    @(negedge clk);
    check(!done, "R10 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    logic [31:0] amask [9];
    void'($urandom(32'd20240611));
    amask = '{32'h86186186, 32'h18618618, 32'h30c30c30, 32'ha28a28a2, 32'h8a28a28a,
              32'h14514514, 32'h28a28a28, 32'h92492492, 32'h24924924};
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_valid, "R1 reset state", {61'd0, busy, done, wr_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wr_valid, "R1 idle after reset", {61'd0, busy, done, wr_valid}, 64'd0);

    // typical fill: basic stage then nine aggressor stages
    run_job(32'h0, 32'h01010101, 8'd8, 12'd0, 100, 1'b0);
    for (int a = 0; a < 9; a++)
      run_job(amask[a], 32'h41041041, 8'd6, 12'(8 + a * 6), (a % 2) ? 100 : 60, 1'b0);

    run_job(32'hFFFF0000, 32'h0F0F0F0F, 8'd0, 12'd5, 100, 1'b0); // R8
    run_job(32'h12345678, 32'h87654321, 8'd1, 12'd100, 50, 1'b1); // R9 poke
    run_job(32'hA5A5A5A5, 32'h80000001, 8'd10, 12'd4090, 70, 1'b1); // R5 wrap
    run_job(32'h00000001, 32'h80000000, 8'd40, 12'd200, 30, 1'b0); // R6 wrap
    run_job($urandom, $urandom, 8'd70, 12'd300, 90, 1'b0);
    for (int k = 0; k < 10; k++)
      run_job($urandom, $urandom, 8'($urandom % 20), 12'($urandom), 30 + int'($urandom % 71), k[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule